// File: doc/BRIEF.md
# Renaming Register File with Mode-Banked Shadow Copies

This block holds the architectural registers of an out-of-order core and renames them in place. Every physical entry carries a valid flag, a 6-bit producer tag and a 32-bit value. When decode sends a destination register with a freshly assigned tag, the entry is marked as waiting on that tag. The file watches several result buses. Each bus carries a valid bit, a tag and data. A waiting entry takes the data from the bus whose tag matches the tag it holds, and then becomes valid again.

There are sixteen architectural indices, and index 15 is the program counter. A 2-bit processor mode decides which physical entry an index reaches, so that the privileged modes see their own private copies of certain registers. In total there are 27 physical entries. The read ports give decode either a ready value or the tag that an operand has to wait on. A read also picks up a matching broadcast in the same cycle, so an operand whose result appears on a bus in that cycle is returned as ready.

Top module: `rnrf_top`

## Requirements
- R1: After reset every physical entry is valid, with value 0 and tag 0.
- R2: A rename (ren_valid_i high) clears the valid flag of the selected entry and loads ren_tag_i into its tag. Both take effect on the next clock edge.
- R3: An invalid entry whose tag equals the tag of a valid result bus takes that bus's data and is valid from the next clock edge. If several buses match, the bus with the lowest number supplies the data.
- R4: A valid entry is not changed by any broadcast, even one whose tag equals the tag it holds.
- R5: Renaming an entry that is already waiting replaces its tag. A later broadcast of the replaced tag leaves the entry invalid.
- R6: If a rename and a broadcast of the entry's current tag arrive in the same cycle, the rename wins and the entry stays invalid under the new tag.
- R7: A read port returns rd_valid_o=1 and the stored value when the entry is valid. Otherwise it returns rd_valid_o=0 and the entry's tag. In the cycle of a rename, a read shows the state before the rename.
- R8: A read of an invalid entry whose tag matches a valid bus in the same cycle returns rd_valid_o=1 and that bus's data, using the same lowest-bus-first priority.
- R9: Mode encoding is 0 user, 1 supervisor, 2 interrupt, 3 fast interrupt. Fast-interrupt mode has private copies of indices 8 to 14. Supervisor and interrupt modes each have private copies of indices 13 and 14. All other indices, including 15, are shared with user mode.
- R10: The mode input selects the physical entry for renames as well as for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Processor mode (0 user, 1 supervisor, 2 interrupt, 3 fast interrupt) |
| ren_valid_i | input | 1 | Rename request this cycle |
| ren_idx_i | input | 4 | Architectural destination index |
| ren_tag_i | input | 6 | New producer tag |
| bus_valid_i | input | NUM_BUS | Result bus valid flags |
| bus_tag_i | input | NUM_BUS*6 | Result bus tags, bus b at bits [b*6 +: 6] |
| bus_data_i | input | NUM_BUS*32 | Result bus data, bus b at bits [b*32 +: 32] |
| rd_idx_i | input | NUM_RD*4 | Read indices, port p at bits [p*4 +: 4] |
| rd_valid_o | output | NUM_RD | Operand ready per port |
| rd_tag_o | output | NUM_RD*6 | Tag to wait on per port |
| rd_data_o | output | NUM_RD*32 | Operand value per port |

## Verification
The hardest case to reach from the ports is an entry that has been renamed twice and still waits on its newest tag. The stale producer's broadcast has to arrive in that state, either in a later cycle or in the same cycle as the second rename. The bench reaches it by issuing back-to-back renames of one index. It then drives the older tag on a bus, alone or together with the rename, and reads the index back to confirm that the entry is still invalid under the newer tag. Banking is checked by writing distinct values to the same index in different modes and reading each one back under every mode.

// File: rtl/rnrf_pkg.sv
package rnrf_pkg;
    localparam int TAG_W   = 6;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;
    localparam int PHYS_N  = 27;
    localparam int PHYS_W  = $clog2(PHYS_N);
    localparam int FIQ_LO_BASE = 16;  // fast-interrupt copies of 8..12
    localparam int SUP_BASE    = 21;  // supervisor copies of 13..14
    localparam int IRQ_BASE    = 23;  // interrupt copies of 13..14
    localparam int FIQ_HI_BASE = 25;  // fast-interrupt copies of 13..14

    typedef enum logic [1:0] {
        MODE_USR = 2'd0,
        MODE_SUP = 2'd1,
        MODE_IRQ = 2'd2,
        MODE_FIQ = 2'd3
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        entry_t [PHYS_N-1:0] ent;
    } state_t;
endpackage

// File: rtl/rnrf_bank_map.sv
module rnrf_bank_map
    import rnrf_pkg::*;
(
    input  logic [1:0]        mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [PHYS_W-1:0] phys_o
);
    logic is_hi;   // index 13 or 14
    logic is_mid;  // index 8..12
    logic [PHYS_W-1:0] hi_off;
    logic [PHYS_W-1:0] mid_off;

    always_comb begin
        is_hi   = (idx_i == 4'd13) || (idx_i == 4'd14);
        is_mid  = (idx_i >= 4'd8) && (idx_i <= 4'd12);
        hi_off  = PHYS_W'(idx_i - 4'd13);
        mid_off = PHYS_W'(idx_i - 4'd8);
        phys_o  = PHYS_W'(idx_i);
        case (mode_e'(mode_i))
            MODE_SUP: if (is_hi) phys_o = PHYS_W'(SUP_BASE) + hi_off;
            MODE_IRQ: if (is_hi) phys_o = PHYS_W'(IRQ_BASE) + hi_off;
            MODE_FIQ: begin
                if (is_hi)       phys_o = PHYS_W'(FIQ_HI_BASE) + hi_off;
                else if (is_mid) phys_o = PHYS_W'(FIQ_LO_BASE) + mid_off;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rnrf_bus_match.sv
module rnrf_bus_match
    import rnrf_pkg::*;
#(
    parameter int NUM_BUS = 3
) (
    input  logic [TAG_W-1:0]          tag_i,
    input  logic [NUM_BUS-1:0]        bus_valid_i,
    input  logic [NUM_BUS*TAG_W-1:0]  bus_tag_i,
    input  logic [NUM_BUS*DATA_W-1:0] bus_data_i,
    output logic                      hit_o,
    output logic [DATA_W-1:0]         data_o
);
    // Scan from the highest bus down so the lowest matching bus is the last one written.
    always_comb begin
        hit_o  = 1'b0;
        data_o = '0;
        for (int b = NUM_BUS - 1; b >= 0; b--) begin
            if (bus_valid_i[b] && (bus_tag_i[b*TAG_W +: TAG_W] == tag_i)) begin
                hit_o  = 1'b1;
                data_o = bus_data_i[b*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/rnrf_top.sv
module rnrf_top
    import rnrf_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int NUM_RD  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_i,
    input  logic                      ren_valid_i,
    input  logic [IDX_W-1:0]          ren_idx_i,
    input  logic [TAG_W-1:0]          ren_tag_i,
    input  logic [NUM_BUS-1:0]        bus_valid_i,
    input  logic [NUM_BUS*TAG_W-1:0]  bus_tag_i,
    input  logic [NUM_BUS*DATA_W-1:0] bus_data_i,
    input  logic [NUM_RD*IDX_W-1:0]   rd_idx_i,
    output logic [NUM_RD-1:0]         rd_valid_o,
    output logic [NUM_RD*TAG_W-1:0]   rd_tag_o,
    output logic [NUM_RD*DATA_W-1:0]  rd_data_o
);
    state_t st_q, st_d;

    logic [PHYS_W-1:0]                ren_phys;
    logic [PHYS_N-1:0]                ent_hit;
    logic [PHYS_N-1:0][DATA_W-1:0]    ent_bdata;
    logic [NUM_RD-1:0][PHYS_W-1:0]    rd_phys;

    rnrf_bank_map ren_map_i (
        .mode_i (mode_i),
        .idx_i  (ren_idx_i),
        .phys_o (ren_phys)
    );

    // One tag comparator bank per physical entry; shared by capture and read forwarding.
    for (genvar e = 0; e < PHYS_N; e++) begin : g_ent
        rnrf_bus_match #(.NUM_BUS(NUM_BUS)) match_i (
            .tag_i       (st_q.ent[e].tag),
            .bus_valid_i (bus_valid_i),
            .bus_tag_i   (bus_tag_i),
            .bus_data_i  (bus_data_i),
            .hit_o       (ent_hit[e]),
            .data_o      (ent_bdata[e])
        );
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        rnrf_bank_map rd_map_i (
            .mode_i (mode_i),
            .idx_i  (rd_idx_i[r*IDX_W +: IDX_W]),
            .phys_o (rd_phys[r])
        );

        entry_t sel;
        logic   fwd;
        always_comb begin
            sel = st_q.ent[rd_phys[r]];
            fwd = !sel.valid && ent_hit[rd_phys[r]];
            rd_valid_o[r]                    = sel.valid || fwd;
            rd_tag_o[r*TAG_W +: TAG_W]       = sel.tag;
            rd_data_o[r*DATA_W +: DATA_W]    = sel.valid ? sel.data
                                             : (fwd ? ent_bdata[rd_phys[r]] : '0);
        end
    end

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < PHYS_N; e++) begin
            if (!st_q.ent[e].valid && ent_hit[e]) begin
                st_d.ent[e].valid = 1'b1;
                st_d.ent[e].data  = ent_bdata[e];
            end
        end
        // Rename is applied last so it overrides a same-cycle capture.
        if (ren_valid_i) begin
            st_d.ent[ren_phys].valid = 1'b0;
            st_d.ent[ren_phys].tag   = ren_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < PHYS_N; e++) begin
                st_q.ent[e].valid <= 1'b1;
                st_q.ent[e].tag   <= '0;
                st_q.ent[e].data  <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rnrf_chk.sv
module rnrf_chk
    import rnrf_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int NUM_RD  = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ren_valid_i,
    input logic [PHYS_W-1:0]             ren_phys,
    input logic [TAG_W-1:0]              ren_tag_i,
    input logic [NUM_BUS-1:0]            bus_valid_i,
    input logic [NUM_BUS*TAG_W-1:0]      bus_tag_i,
    input entry_t [PHYS_N-1:0]           ent_q,
    input logic [NUM_RD-1:0][PHYS_W-1:0] rd_phys,
    input logic [NUM_RD-1:0]             rd_valid_o,
    input logic [NUM_RD*TAG_W-1:0]       rd_tag_o,
    input logic [NUM_RD*DATA_W-1:0]      rd_data_o
);
    function automatic logic tag_on_bus(input logic [TAG_W-1:0] t);
        logic f;
        f = 1'b0;
        for (int b = 0; b < NUM_BUS; b++)
            if (bus_valid_i[b] && bus_tag_i[b*TAG_W +: TAG_W] == t) f = 1'b1;
        return f;
    endfunction

    // R2: a rename leaves its entry waiting on the new tag
    assert_rename_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid_i |=> (!ent_q[$past(ren_phys)].valid
                         && ent_q[$past(ren_phys)].tag == $past(ren_tag_i)));

    for (genvar e = 0; e < PHYS_N; e++) begin : g_e
        logic hit_here;
        logic ren_here;
        assign hit_here = tag_on_bus(ent_q[e].tag);
        assign ren_here = ren_valid_i && (ren_phys == PHYS_W'(e));

        // R4: valid entries are untouched by broadcasts
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_q[e].valid && !ren_here) |=>
                (ent_q[e].valid && ent_q[e].data == $past(ent_q[e].data)));

        // R3: a waiting entry with a matching broadcast becomes valid
        assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ent_q[e].valid && hit_here && !ren_here) |=> ent_q[e].valid);
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_r
        // R7: a valid entry reads as ready with its stored value
        assert_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ent_q[rd_phys[r]].valid |->
                (rd_valid_o[r] && rd_data_o[r*DATA_W +: DATA_W] == ent_q[rd_phys[r]].data));

        // R8: a not-ready read never coexists with a broadcast of its tag
        assert_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_valid_o[r] |-> !tag_on_bus(rd_tag_o[r*TAG_W +: TAG_W]));
    end
endmodule

bind rnrf_top rnrf_chk #(.NUM_BUS(NUM_BUS), .NUM_RD(NUM_RD)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ren_valid_i (ren_valid_i),
    .ren_phys    (ren_phys),
    .ren_tag_i   (ren_tag_i),
    .bus_valid_i (bus_valid_i),
    .bus_tag_i   (bus_tag_i),
    .ent_q       (st_q.ent),
    .rd_phys     (rd_phys),
    .rd_valid_o  (rd_valid_o),
    .rd_tag_o    (rd_tag_o),
    .rd_data_o   (rd_data_o)
);

// File: tb/rnrf_tb.sv
`timescale 1ns/1ps
module rnrf_top_tb_top;
    localparam int NB = 3;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          ren_valid_i = 1'b0;
    logic [3:0]    ren_idx_i = '0;
    logic [5:0]    ren_tag_i = '0;
    logic [NB-1:0] bus_valid_i = '0;
    logic [NB*6-1:0]  bus_tag_i = '0;
    logic [NB*32-1:0] bus_data_i = '0;
    logic [NR*4-1:0]  rd_idx_i = '0;
    logic [NR-1:0]    rd_valid_o;
    logic [NR*6-1:0]  rd_tag_o;
    logic [NR*32-1:0] rd_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rnrf_top #(.NUM_BUS(NB), .NUM_RD(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .ren_valid_i(ren_valid_i), .ren_idx_i(ren_idx_i), .ren_tag_i(ren_tag_i),
        .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i), .bus_data_i(bus_data_i),
        .rd_idx_i(rd_idx_i), .rd_valid_o(rd_valid_o), .rd_tag_o(rd_tag_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ren_valid_i = 1'b0;
        bus_valid_i = '0;
    endtask

    task automatic bus(input int b, input logic [5:0] t, input logic [31:0] d);
        bus_valid_i[b] = 1'b1;
        bus_tag_i[b*6 +: 6] = t;
        bus_data_i[b*32 +: 32] = d;
    endtask

    task automatic ren(input logic [3:0] idx, input logic [5:0] t);
        ren_valid_i = 1'b1;
        ren_idx_i = idx;
        ren_tag_i = t;
    endtask

    // Read one port in the current mode; check ready+value or not-ready+tag.
    task automatic rd(input int p, input logic [3:0] idx, input bit v,
                      input logic [31:0] val, input string req);
        rd_idx_i[p*4 +: 4] = idx;
        #1;
        chk(rd_valid_o[p] == v, req, "ready", 32'(rd_valid_o[p]), 32'(v));
        if (v) chk(rd_data_o[p*32 +: 32] == val, req, "value", rd_data_o[p*32 +: 32], val);
        else   chk(rd_tag_o[p*6 +: 6] == val[5:0], req, "tag", 32'(rd_tag_o[p*6 +: 6]), val);
    endtask

    task automatic fill(input logic [3:0] idx, input logic [5:0] t, input logic [31:0] d);
        ren(idx, t); tick(); idle();
        bus(0, t, d); tick(); idle();
    endtask

    task automatic t_reset();
        rd(0, 4'd0, 1'b1, 32'h0, "R1");
        rd(1, 4'd15, 1'b1, 32'h0, "R1");
        mode_i = 2'd3; rd(0, 4'd13, 1'b1, 32'h0, "R1"); mode_i = 2'd0;
    endtask

    task automatic t_rename_capture();
        ren(4'd3, 6'd5);
        rd(0, 4'd3, 1'b1, 32'h0, "R7");          // pre-rename view
        tick(); idle();
        rd(0, 4'd3, 1'b0, 32'd5, "R2");
        bus(1, 6'd5, 32'hA5A5_0003);
        rd(1, 4'd3, 1'b1, 32'hA5A5_0003, "R8");  // same-cycle forward
        tick(); idle();
        rd(0, 4'd3, 1'b1, 32'hA5A5_0003, "R3");
    endtask

    task automatic t_valid_ignore();
        bus(0, 6'd5, 32'hDEAD_BEEF); tick(); idle();
        rd(0, 4'd3, 1'b1, 32'hA5A5_0003, "R4");
    endtask

    task automatic t_waw();
        ren(4'd4, 6'd7); tick();
        ren(4'd4, 6'd9); tick(); idle();
        bus(0, 6'd7, 32'h1111); tick(); idle();
        rd(0, 4'd4, 1'b0, 32'd9, "R5");
        bus(2, 6'd9, 32'h2222); tick(); idle();
        rd(0, 4'd4, 1'b1, 32'h2222, "R5");
    endtask

    task automatic t_race();
        ren(4'd5, 6'd10); tick();
        ren(4'd5, 6'd11); bus(0, 6'd10, 32'h3333); tick(); idle();
        rd(0, 4'd5, 1'b0, 32'd11, "R6");
        bus(1, 6'd11, 32'h4444); tick(); idle();
        rd(0, 4'd5, 1'b1, 32'h4444, "R6");
    endtask

    task automatic t_priority();
        ren(4'd6, 6'd20); tick(); idle();
        bus(2, 6'd20, 32'h77); bus(1, 6'd20, 32'h66);
        rd(0, 4'd6, 1'b1, 32'h66, "R8");
        tick(); idle();
        rd(0, 4'd6, 1'b1, 32'h66, "R3");
    endtask

    task automatic t_banks();
        fill(4'd13, 6'd30, 32'h0000_0013);             // user r13
        mode_i = 2'd1; rd(0, 4'd13, 1'b1, 32'h0, "R9");
        fill(4'd13, 6'd31, 32'h0000_5013);             // supervisor r13 (R10)
        mode_i = 2'd2; rd(0, 4'd13, 1'b1, 32'h0, "R9");
        mode_i = 2'd3; rd(0, 4'd13, 1'b1, 32'h0, "R9");
        fill(4'd8, 6'd32, 32'h0000_F008);              // fast r8
        mode_i = 2'd0;
        rd(0, 4'd8, 1'b1, 32'h0, "R10");
        rd(1, 4'd13, 1'b1, 32'h0000_0013, "R10");
        mode_i = 2'd1;
        rd(0, 4'd13, 1'b1, 32'h0000_5013, "R10");
        rd(1, 4'd8, 1'b1, 32'h0, "R9");
        mode_i = 2'd3;
        rd(0, 4'd8, 1'b1, 32'h0000_F008, "R10");
        fill(4'd15, 6'd33, 32'h0000_0100);             // shared program counter
        fill(4'd7, 6'd34, 32'h0000_0077);              // shared r7
        mode_i = 2'd0;
        rd(0, 4'd15, 1'b1, 32'h0000_0100, "R9");
        rd(1, 4'd7, 1'b1, 32'h0000_0077, "R9");
        mode_i = 2'd2;
        fill(4'd14, 6'd35, 32'h0000_1414);             // interrupt r14
        rd(0, 4'd14, 1'b1, 32'h0000_1414, "R10");
        rd(1, 4'd8, 1'b1, 32'h0, "R9");
        mode_i = 2'd1; rd(0, 4'd14, 1'b1, 32'h0, "R9");
        mode_i = 2'd0; rd(0, 4'd14, 1'b1, 32'h0, "R9");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_rename_capture();
        t_valid_ignore();
        t_waw();
        t_race();
        t_priority();
        t_banks();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule